// File: doc/BRIEF.md
# Synchronous Serial Host Port

This block is the slave side of a serial link through which a host controller talks to a decoder core. The host owns the bit clock. It drives one frame-sync line to start inbound traffic and a second one to start outbound traffic, sends data on a single input pin, and receives data on a single output pin. Inbound traffic is either a 16-bit command, made of an 8-bit opcode and an 8-bit ID, or a block of 256 sixteen-bit words (512 bytes). Outbound traffic is always a block of 256 words. All bit sequencing runs in the host clock domain, with sampling on falling edges and launching on rising edges. Each finished word is passed to the system clock domain, where the core sees single-cycle strobes and pulls outbound words from a first-word-fall-through FIFO.

Two status outputs tell the host what it may do. The ready flag shows whether the core can accept or supply data, and any transfer that begins while the flag is low is dropped. The frame line changes level each time the core reports that one frame has been fully processed, so the host can count frames by counting level changes. If the core has no word ready when an outbound word must start, the port sends zeros for that word and raises a sticky underrun indication.

Top module: `shp_host_port`

## Requirements
- R1: While reset is held low, and right after it is released, the outputs are at rest: `host_ready`, `frame_flip`, `cmd_valid`, `wr_valid`, `rd_pop`, `underrun` and `host_sdo` are all 0.
- R2: With `core_blk_mode`=0, a falling edge of `host_sclk` that sees `host_rx_sync` high starts a command. The next 16 falling edges capture `host_sdi` MSB first. After that, `cmd_valid` pulses once, with `cmd_op` set to bits 15..8 and `cmd_id` set to bits 7..0.
- R3: With `core_blk_mode`=1, the same start captures 4096 bits on the following falling edges. This gives 256 `wr_valid` pulses, each carrying one 16-bit word assembled MSB first, in arrival order.
- R4: A falling edge that sees `host_tx_sync` high starts a read. Each of the next 4096 rising edges drives one bit on `host_sdo`, MSB first within each word, with the words in FIFO order. `rd_pop` pulses once per word taken, and never in two consecutive cycles.
- R5: After the last bit, the port ignores both frame syncs for 1 falling edge after a command and for 3 falling edges after a block. The edge after that may start a new transfer.
- R6: A transfer whose start edge occurs while the port sees `host_ready` low is ignored. It produces no strobe, `host_sdo` stays 0, and no underrun is raised. The port accepts traffic again once both frame syncs have been seen low.
- R7: `host_ready` equals `core_ready` delayed by one system clock cycle.
- R8: `frame_flip` inverts in the cycle after each cycle in which `core_frame_done` is high, and holds its level otherwise.
- R9: If no word is available when an outbound word must start, that word is sent as zeros and `underrun` goes to 1. It then stays at 1 until reset.
- R10: `cmd_valid` and `wr_valid` are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, held long enough to span edges of both clocks |
| host_sclk | input | 1 | Host-driven bit clock |
| host_rx_sync | input | 1 | Inbound frame sync |
| host_tx_sync | input | 1 | Outbound frame sync |
| host_sdi | input | 1 | Serial data from host, sampled on falling edges |
| host_sdo | output | 1 | Serial data to host, launched on rising edges |
| host_ready | output | 1 | Ready/busy request flag to host |
| frame_flip | output | 1 | Frame-done level that changes once per processed frame |
| core_ready | input | 1 | Core can accept or supply data |
| core_blk_mode | input | 1 | Next inbound transfer is a block (1) or a command (0) |
| core_frame_done | input | 1 | One-cycle pulse per processed frame |
| cmd_valid | output | 1 | One-cycle strobe for a received command |
| cmd_op | output | 8 | Command opcode |
| cmd_id | output | 8 | Command ID |
| wr_valid | output | 1 | One-cycle strobe for a received data word |
| wr_data | output | 16 | Received data word |
| rd_data | input | 16 | Head word of the outbound FIFO |
| rd_avail | input | 1 | Outbound FIFO is not empty |
| rd_pop | output | 1 | Takes the head word of the outbound FIFO |
| underrun | output | 1 | Sticky flag: an outbound word was replaced by zeros |

## Verification
Two commands are sent: one with a distinct opcode and ID, and one with a bit pattern that would come out mirrored if the bit order or the opcode/ID split were wrong. A second pair of commands is sent with the inbound sync held high on the trailing edge. A one-edge slip in the tail handling would shift every bit of the second command. Full inbound and outbound blocks use a different word on every index, so a dropped, repeated or reordered word shows up as a data mismatch. The underrun case starves the FIFO after three words, which separates good words from zero-filled ones. A gated read started while the flag is low must leave both the output pin and the underrun flag untouched.

// File: rtl/shp_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the serial host port.
package shp_pkg;
    localparam int unsigned SHP_WORD_W      = 16;
    localparam int unsigned SHP_BLOCK_WORDS = 256;
    localparam int unsigned SHP_CMD_TAIL    = 1;
    localparam int unsigned SHP_BLK_TAIL    = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_TX,
        ST_DROP,
        ST_TAIL
    } eng_state_e;
endpackage

// File: rtl/shp_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser for a vector of independent quasi-static bits.
// FALLING selects the sampling edge, so a negative-edge domain can reuse it.
// Assumes each bit is a level or toggle that holds for several destination edges.
module shp_sync #(
    parameter int unsigned WIDTH   = 1,
    parameter bit          FALLING = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    generate
        if (FALLING) begin : g_neg
            // Two-stage capture on the falling edge.
            always_ff @(negedge clk) begin
                if (!rst_n) begin
                    stage1 <= '0;
                    q      <= '0;
                end else begin
                    stage1 <= d;
                    q      <= stage1;
                end
            end
        end else begin : g_pos
            // Two-stage capture on the rising edge.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage1 <= '0;
                    q      <= '0;
                end else begin
                    stage1 <= d;
                    q      <= stage1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/shp_engine.sv
`timescale 1ns/1ps
// Bit-clock engine: frame detection, bit counting, shifting and tail skipping.
// All control runs on falling edges of the host clock; only the output pin is
// launched on rising edges. Assumes the host clock keeps running through reset,
// and that the holding word is stable whenever data_tgl_s differs from take_tgl.
module shp_engine
    import shp_pkg::*;
#(
    parameter int unsigned WORD_W      = SHP_WORD_W,
    parameter int unsigned BLOCK_WORDS = SHP_BLOCK_WORDS,
    parameter int unsigned CMD_TAIL    = SHP_CMD_TAIL,
    parameter int unsigned BLK_TAIL    = SHP_BLK_TAIL
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              rx_sync,
    input  logic              tx_sync,
    input  logic              sdi,
    input  logic              ready_s,
    input  logic              blk_mode_s,
    input  logic              data_tgl_s,
    input  logic [WORD_W-1:0] hold_word,
    output logic              sdo,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_is_blk,
    output logic              rx_tgl,
    output logic              take_tgl,
    output logic              under_flag
);
    localparam int unsigned BLOCK_BITS = WORD_W * BLOCK_WORDS;
    localparam int unsigned CNT_W      = $clog2(BLOCK_BITS);
    localparam int unsigned BIT_W      = $clog2(WORD_W);
    localparam int unsigned TAIL_MAX   = (BLK_TAIL > CMD_TAIL) ? BLK_TAIL : CMD_TAIL;
    localparam int unsigned TAIL_W     = $clog2(TAIL_MAX + 1);
    localparam logic [CNT_W-1:0]  BLK_LAST = CNT_W'(BLOCK_BITS - 1);
    localparam logic [CNT_W-1:0]  CMD_LAST = CNT_W'(WORD_W - 1);
    localparam logic [TAIL_W-1:0] T_BLK    = TAIL_W'(BLK_TAIL);
    localparam logic [TAIL_W-1:0] T_CMD    = TAIL_W'(CMD_TAIL);

    eng_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [TAIL_W-1:0] tail_left;
    logic [WORD_W-1:0] shreg;
    logic              cur_blk;
    logic              hold_avail;
    logic              word_end;
    logic              rx_last;
    logic [WORD_W-1:0] rx_next;

    // Derived conditions for the current falling edge.
    always_comb begin
        hold_avail = data_tgl_s ^ take_tgl;
        word_end   = &cnt[BIT_W-1:0];
        rx_last    = (cnt == (cur_blk ? BLK_LAST : CMD_LAST));
        rx_next    = {shreg[WORD_W-2:0], sdi};
    end

    // Transfer state machine, sampling on falling edges.
    always_ff @(negedge sclk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            tail_left  <= '0;
            shreg      <= '0;
            cur_blk    <= 1'b0;
            rx_word    <= '0;
            rx_is_blk  <= 1'b0;
            rx_tgl     <= 1'b0;
            take_tgl   <= 1'b0;
            under_flag <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (rx_sync) begin
                        if (ready_s) begin
                            state   <= ST_RX;
                            cur_blk <= blk_mode_s;
                        end else begin
                            state <= ST_DROP;
                        end
                    end else if (tx_sync) begin
                        if (ready_s) begin
                            state <= ST_TX;
                            if (hold_avail) begin
                                shreg    <= hold_word;
                                take_tgl <= ~take_tgl;
                            end else begin
                                shreg      <= '0;
                                under_flag <= 1'b1;
                            end
                        end else begin
                            state <= ST_DROP;
                        end
                    end
                end
                ST_RX: begin
                    shreg <= rx_next;
                    if (word_end) begin
                        rx_word   <= rx_next;
                        rx_is_blk <= cur_blk;
                        rx_tgl    <= ~rx_tgl;
                    end
                    if (rx_last) begin
                        state     <= ST_TAIL;
                        tail_left <= cur_blk ? T_BLK : T_CMD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_TX: begin
                    if (cnt == BLK_LAST) begin
                        state     <= ST_TAIL;
                        tail_left <= T_BLK;
                    end else begin
                        cnt <= cnt + 1'b1;
                        if (word_end) begin
                            if (hold_avail) begin
                                shreg    <= hold_word;
                                take_tgl <= ~take_tgl;
                            end else begin
                                shreg      <= '0;
                                under_flag <= 1'b1;
                            end
                        end else begin
                            shreg <= {shreg[WORD_W-2:0], 1'b0};
                        end
                    end
                end
                ST_DROP: begin
                    if (!rx_sync && !tx_sync) state <= ST_IDLE;
                end
                ST_TAIL: begin
                    tail_left <= tail_left - 1'b1;
                    if (tail_left == TAIL_W'(1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output pin launch on rising edges, so the host latches on falling edges.
    always_ff @(posedge sclk) begin
        if (!rst_n) sdo <= 1'b0;
        else        sdo <= (state == ST_TX) ? shreg[WORD_W-1] : 1'b0;
    end
endmodule

// File: rtl/shp_core_side.sv
`timescale 1ns/1ps
// System-clock side: turns word toggles into strobes, keeps one outbound word
// in a holding register, and drives the ready, frame and underrun outputs.
// Assumes received words stay stable for many system cycles after their toggle.
module shp_core_side #(
    parameter int unsigned WORD_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     core_ready,
    input  logic                     frame_done,
    input  logic                     rx_tgl_s,
    input  logic                     rx_is_blk,
    input  logic [WORD_W-1:0]        rx_word,
    input  logic                     take_tgl_s,
    input  logic                     under_s,
    input  logic                     rd_avail,
    input  logic [WORD_W-1:0]        rd_data,
    output logic                     host_ready,
    output logic                     frame_flip,
    output logic                     cmd_valid,
    output logic [WORD_W/2-1:0]      cmd_op,
    output logic [WORD_W-WORD_W/2-1:0] cmd_id,
    output logic                     wr_valid,
    output logic [WORD_W-1:0]        wr_data,
    output logic                     rd_pop,
    output logic [WORD_W-1:0]        hold_word,
    output logic                     data_tgl,
    output logic                     underrun
);
    logic rx_seen;
    logic new_word;
    logic hold_full;

    // Word arrival detection and holding-stage occupancy.
    always_comb begin
        new_word  = rx_tgl_s ^ rx_seen;
        hold_full = data_tgl ^ take_tgl_s;
        rd_pop    = rst_n & ~hold_full & rd_avail;
    end

    // Inbound strobes and their data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_seen   <= 1'b0;
            cmd_valid <= 1'b0;
            wr_valid  <= 1'b0;
            cmd_op    <= '0;
            cmd_id    <= '0;
            wr_data   <= '0;
        end else begin
            rx_seen   <= rx_tgl_s;
            cmd_valid <= new_word & ~rx_is_blk;
            wr_valid  <= new_word & rx_is_blk;
            if (new_word && !rx_is_blk) {cmd_op, cmd_id} <= rx_word;
            if (new_word && rx_is_blk)  wr_data <= rx_word;
        end
    end

    // Outbound holding register refill from the FIFO head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_word <= '0;
            data_tgl  <= 1'b0;
        end else if (rd_pop) begin
            hold_word <= rd_data;
            data_tgl  <= ~data_tgl;
        end
    end

    // Status outputs toward the host and the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_ready <= 1'b0;
            frame_flip <= 1'b0;
            underrun   <= 1'b0;
        end else begin
            host_ready <= core_ready;
            frame_flip <= frame_flip ^ frame_done;
            underrun   <= under_s;
        end
    end
endmodule

// File: rtl/shp_host_port.sv
`timescale 1ns/1ps
// Serial host port top: bit-clock engine, system-side logic and the two
// synchroniser banks between them. Assumes rst_n spans edges of both clocks
// and that core_blk_mode is stable while the port is idle.
module shp_host_port
    import shp_pkg::*;
#(
    parameter int unsigned WORD_W      = SHP_WORD_W,
    parameter int unsigned BLOCK_WORDS = SHP_BLOCK_WORDS,
    parameter int unsigned CMD_TAIL    = SHP_CMD_TAIL,
    parameter int unsigned BLK_TAIL    = SHP_BLK_TAIL
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_sclk,
    input  logic                       host_rx_sync,
    input  logic                       host_tx_sync,
    input  logic                       host_sdi,
    output logic                       host_sdo,
    output logic                       host_ready,
    output logic                       frame_flip,
    input  logic                       core_ready,
    input  logic                       core_blk_mode,
    input  logic                       core_frame_done,
    output logic                       cmd_valid,
    output logic [WORD_W/2-1:0]        cmd_op,
    output logic [WORD_W-WORD_W/2-1:0] cmd_id,
    output logic                       wr_valid,
    output logic [WORD_W-1:0]          wr_data,
    input  logic [WORD_W-1:0]          rd_data,
    input  logic                       rd_avail,
    output logic                       rd_pop,
    output logic                       underrun
);
    logic              ready_s, blk_mode_s, data_tgl_s;
    logic              rx_tgl_s, take_tgl_s, under_s;
    logic [WORD_W-1:0] rx_word, hold_word;
    logic              rx_is_blk, rx_tgl, take_tgl, under_flag, data_tgl;

    shp_sync #(.WIDTH(3), .FALLING(1'b1)) u_to_sclk (
        .clk   (host_sclk),
        .rst_n (rst_n),
        .d     ({host_ready, core_blk_mode, data_tgl}),
        .q     ({ready_s, blk_mode_s, data_tgl_s})
    );

    shp_sync #(.WIDTH(3), .FALLING(1'b0)) u_to_sys (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({rx_tgl, take_tgl, under_flag}),
        .q     ({rx_tgl_s, take_tgl_s, under_s})
    );

    shp_engine #(
        .WORD_W      (WORD_W),
        .BLOCK_WORDS (BLOCK_WORDS),
        .CMD_TAIL    (CMD_TAIL),
        .BLK_TAIL    (BLK_TAIL)
    ) u_engine (
        .sclk       (host_sclk),
        .rst_n      (rst_n),
        .rx_sync    (host_rx_sync),
        .tx_sync    (host_tx_sync),
        .sdi        (host_sdi),
        .ready_s    (ready_s),
        .blk_mode_s (blk_mode_s),
        .data_tgl_s (data_tgl_s),
        .hold_word  (hold_word),
        .sdo        (host_sdo),
        .rx_word    (rx_word),
        .rx_is_blk  (rx_is_blk),
        .rx_tgl     (rx_tgl),
        .take_tgl   (take_tgl),
        .under_flag (under_flag)
    );

    shp_core_side #(.WORD_W(WORD_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_ready (core_ready),
        .frame_done (core_frame_done),
        .rx_tgl_s   (rx_tgl_s),
        .rx_is_blk  (rx_is_blk),
        .rx_word    (rx_word),
        .take_tgl_s (take_tgl_s),
        .under_s    (under_s),
        .rd_avail   (rd_avail),
        .rd_data    (rd_data),
        .host_ready (host_ready),
        .frame_flip (frame_flip),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_id     (cmd_id),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .rd_pop     (rd_pop),
        .hold_word  (hold_word),
        .data_tgl   (data_tgl),
        .underrun   (underrun)
    );
endmodule

// File: rtl/shp_host_port_chk.sv
`timescale 1ns/1ps
// Protocol checker for the system-side ports of the serial host port.
module shp_host_port_chk (
    input logic clk,
    input logic rst_n,
    input logic core_ready,
    input logic core_frame_done,
    input logic host_ready,
    input logic frame_flip,
    input logic cmd_valid,
    input logic wr_valid,
    input logic rd_pop,
    input logic underrun
);
    // R1: reset drives the registered outputs to rest.
    a_r1_reset_rest: assert property (@(posedge clk)
        !rst_n |=> (!host_ready && !frame_flip && !cmd_valid && !wr_valid && !underrun));

    a_r7_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |=> host_ready);
    a_r7_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        !core_ready |=> !host_ready);

    a_r8_flip_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        core_frame_done |=> (frame_flip != $past(frame_flip)));
    a_r8_hold_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        !core_frame_done |=> $stable(frame_flip));

    a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    a_r10_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    a_r10_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && wr_valid));

    a_r4_pop_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop |=> !rd_pop);
endmodule

bind shp_host_port shp_host_port_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .core_ready      (core_ready),
    .core_frame_done (core_frame_done),
    .host_ready      (host_ready),
    .frame_flip      (frame_flip),
    .cmd_valid       (cmd_valid),
    .wr_valid        (wr_valid),
    .rd_pop          (rd_pop),
    .underrun        (underrun)
);

// File: tb/shp_host_port_tb.sv
`timescale 1ns/1ps
module shp_host_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic rxs = 1'b0, txs = 1'b0, sdi = 1'b0;
    logic sdo, host_ready, frame_flip;
    logic core_ready = 1'b0, blk_mode = 1'b0, frame_done = 1'b0;
    logic cmd_valid, wr_valid, rd_pop, underrun;
    logic [7:0]  cmd_op, cmd_id;
    logic [15:0] wr_data, rd_data;
    logic        rd_avail;

    logic [15:0] mem [0:263];
    int fifo_n = 0;
    int fifo_rd = 0;
    assign rd_avail = (fifo_rd < fifo_n);
    assign rd_data  = mem[fifo_rd];

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [15:0] cmd_log [0:15];
    logic [15:0] wr_log  [0:511];
    int cmd_cnt = 0, wr_cnt = 0, pop_cnt = 0, dbl = 0;
    logic prev_cmd = 1'b0, prev_wr = 1'b0;

    always #2.5 clk = ~clk;

    shp_host_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_sclk(sclk), .host_rx_sync(rxs),
        .host_tx_sync(txs), .host_sdi(sdi), .host_sdo(sdo),
        .host_ready(host_ready), .frame_flip(frame_flip),
        .core_ready(core_ready), .core_blk_mode(blk_mode),
        .core_frame_done(frame_done), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_id(cmd_id), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_data(rd_data), .rd_avail(rd_avail), .rd_pop(rd_pop),
        .underrun(underrun)
    );

    // Bench FIFO model: head advances on each pop.
    always @(posedge clk) if (rd_pop) fifo_rd <= fifo_rd + 1;

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (cmd_valid) begin cmd_log[cmd_cnt % 16] = {cmd_op, cmd_id}; cmd_cnt++; end
        if (wr_valid)  begin wr_log[wr_cnt % 512] = wr_data; wr_cnt++; end
        if (rd_pop) pop_cnt++;
        if ((cmd_valid && prev_cmd) || (wr_valid && prev_wr) || (cmd_valid && wr_valid)) dbl++;
        prev_cmd = cmd_valid;
        prev_wr  = wr_valid;
    end

    function automatic logic [15:0] wpat(input int i);
        return 16'((i * 32'h2F1B) ^ 32'h5AA5);
    endfunction
    function automatic logic [15:0] rpat(input int i);
        return 16'((i * 32'h61C9) + 32'h1234);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One host bit-clock period of 40 ns; sdo is read just before the falling edge.
    task automatic tick(input logic r, input logic t, input logic d, output logic seen);
        rxs = r; txs = t; sdi = d;
        #5 seen = sdo;
        #5 sclk = 1'b0;
        #20 sclk = 1'b1;
        #10;
    endtask

    task automatic idle(input int n);
        logic s;
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, s);
    endtask

    task automatic send_cmd(input logic [15:0] w, input logic tail_r);
        logic s;
        tick(1'b1, 1'b0, 1'b0, s);
        for (int b = 15; b >= 0; b--) tick(b == 15, 1'b0, w[b], s);
        tick(tail_r, 1'b0, 1'b0, s);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle(4);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        chk(host_ready == 0 && frame_flip == 0 && sdo == 0, "R1 status outputs",
            {host_ready, frame_flip, sdo}, 0);
        chk(cmd_valid == 0 && wr_valid == 0 && rd_pop == 0 && underrun == 0, "R1 strobes",
            {cmd_valid, wr_valid, rd_pop, underrun}, 0);
    endtask

    task automatic t_ready;
        @(negedge clk) core_ready = 1'b1;
        @(negedge clk) chk(host_ready == 1, "R7 rise", host_ready, 1);
        core_ready = 1'b0;
        @(negedge clk) chk(host_ready == 0, "R7 fall", host_ready, 0);
        core_ready = 1'b1;
        @(negedge clk) chk(host_ready == 1, "R7 rise again", host_ready, 1);
    endtask

    task automatic t_frame;
        @(negedge clk) frame_done = 1'b1;
        @(negedge clk) frame_done = 1'b0;
        chk(frame_flip == 1, "R8 first flip", frame_flip, 1);
        repeat (5) @(negedge clk);
        chk(frame_flip == 1, "R8 hold", frame_flip, 1);
        frame_done = 1'b1;
        @(negedge clk) frame_done = 1'b0;
        chk(frame_flip == 0, "R8 flip back", frame_flip, 0);
    endtask

    task automatic t_command;
        int c0;
        blk_mode = 1'b0;
        idle(4);
        c0 = cmd_cnt;
        send_cmd(16'h3CA1, 1'b0);
        idle(2);
        chk(cmd_cnt == c0 + 1, "R2 one strobe", cmd_cnt - c0, 1);
        chk(cmd_log[c0 % 16] == 16'h3CA1, "R2 op/id 3C A1", cmd_log[c0 % 16], 16'h3CA1);
        send_cmd(16'h817E, 1'b0);
        idle(2);
        chk(cmd_log[(c0 + 1) % 16] == 16'h817E, "R2 op/id 81 7E", cmd_log[(c0 + 1) % 16], 16'h817E);
    endtask

    task automatic t_tail;
        int c0;
        c0 = cmd_cnt;
        send_cmd(16'hC35A, 1'b1);
        send_cmd(16'h0FF0, 1'b0);
        idle(2);
        chk(cmd_cnt == c0 + 2, "R5 two commands", cmd_cnt - c0, 2);
        chk(cmd_log[c0 % 16] == 16'hC35A, "R5 first", cmd_log[c0 % 16], 16'hC35A);
        chk(cmd_log[(c0 + 1) % 16] == 16'h0FF0, "R5 second after tail", cmd_log[(c0 + 1) % 16], 16'h0FF0);
    endtask

    task automatic t_gating;
        int c0;
        int bad;
        logic s;
        @(negedge clk) core_ready = 1'b0;
        idle(4);
        c0 = cmd_cnt;
        send_cmd(16'h1234, 1'b0);
        idle(2);
        chk(cmd_cnt == c0, "R6 command ignored", cmd_cnt - c0, 0);
        bad = 0;
        tick(1'b0, 1'b1, 1'b0, s);
        for (int i = 0; i < 40; i++) begin
            tick(1'b0, 1'b0, 1'b0, s);
            if (s !== 1'b0) bad++;
        end
        chk(bad == 0 && underrun == 0, "R6 read ignored", {bad[7:0], underrun}, 0);
        @(negedge clk) core_ready = 1'b1;
        idle(4);
        send_cmd(16'h5A00, 1'b0);
        idle(2);
        chk(cmd_cnt == c0 + 1 && cmd_log[c0 % 16] == 16'h5A00, "R6 accepted after ready",
            cmd_log[c0 % 16], 16'h5A00);
    endtask

    task automatic t_block_write;
        int w0, bad;
        logic s;
        logic [15:0] w;
        blk_mode = 1'b1;
        idle(4);
        w0 = wr_cnt;
        tick(1'b1, 1'b0, 1'b0, s);
        for (int i = 0; i < 256; i++) begin
            w = wpat(i);
            for (int b = 15; b >= 0; b--) tick((i * 16 + 15 - b) <= 4080, 1'b0, w[b], s);
        end
        idle(3);
        idle(2);
        bad = 0;
        for (int i = 0; i < 256; i++) if (wr_log[(w0 + i) % 512] !== wpat(i)) bad++;
        chk(wr_cnt == w0 + 256, "R3 word count", wr_cnt - w0, 256);
        chk(bad == 0, "R3 word data", bad, 0);
        chk(dbl == 0 && cmd_cnt >= 0, "R10 single pulses", dbl, 0);
        blk_mode = 1'b0;
        idle(4);
    endtask

    task automatic t_read(input int nwords, input int base, input string tag);
        int p0, bad;
        logic s;
        logic [15:0] got, exp;
        p0 = pop_cnt;
        for (int i = 0; i < nwords; i++) mem[base + i] = rpat(base + i);
        fifo_n = base + nwords;
        idle(4);
        tick(1'b0, 1'b1, 1'b0, s);
        bad = 0;
        for (int i = 0; i < 256; i++) begin
            for (int b = 15; b >= 0; b--) begin
                tick(1'b0, (i * 16 + 15 - b) <= 4080, 1'b0, s);
                got[b] = s;
            end
            exp = (i < nwords) ? rpat(base + i) : 16'h0000;
            if (got !== exp) bad++;
        end
        idle(3);
        idle(2);
        chk(bad == 0, {tag, " bit stream"}, bad, 0);
        chk(pop_cnt - p0 == nwords, {tag, " pop count"}, pop_cnt - p0, nwords);
        chk(underrun == (nwords < 256), {tag, " underrun flag"}, underrun, nwords < 256);
    endtask

    initial begin
        t_reset();
        t_ready();
        t_frame();
        t_command();
        t_tail();
        t_gating();
        t_block_write();
        t_read(256, 0, "R4 full read");
        t_read(3, 256, "R9 starved read");
        idle(4);
        chk(underrun == 1, "R9 sticky", underrun, 1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(190000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule